// File: doc/BRIEF.md
# Remote Shutdown and Protection Fault Latch

This block decides when a switching supply's converter must be held off. A host drives a remote request (high asks for the supply to be off), and a set of protection comparators deliver single-bit flags: over-voltage for several rails, under-voltage for several rails, and one extra protection input. The block produces a registered shutdown signal (high means converter off) for the PWM inhibit. It also presents the time-filtered remote request, so that power-good logic can drop its output before the rails collapse.

The remote request passes through an asymmetric filter. It uses a short delay toward "off" and a long delay toward "on". A request that reverses before its delay expires leaves no trace. Any protection flag sets a fault latch that forces shutdown. Under-voltage flags are only honoured once a blanking window has run out. The window starts after reset and again each time the filtered remote request returns low. The fault latch can only be cleared by the filtered remote request going high. A trip is therefore recovered by cycling the remote input high and then low.

Top module: `psu_shutdown_ctrl`

## Requirements
- R1: With remote_off_i held high from a given cycle, rem_delayed_o rises after OFF_DLY_CYC rising edges, and shutdown_o rises one edge later.
- R2: With remote_off_i held low and no fault latched, rem_delayed_o falls after RUN_DLY_CYC rising edges, and shutdown_o falls one edge later.
- R3: A remote_off_i level that differs from rem_delayed_o for fewer edges than its delay changes neither output, and the count restarts from zero on the next change.
- R4: Any bit of ov_flag_i sampled high sets the fault latch, and shutdown_o is high two edges after the flag is applied.
- R5: ext_prot_i sampled high trips the fault latch in the same way as an over-voltage flag.
- R6: Once the blanking window has expired, any bit of uv_flag_i sampled high trips the fault latch.
- R7: uv_flag_i is ignored during the first UV_BLANK_CYC rising edges after reset. shutdown_o stays low when the flag is removed before the window ends.
- R8: A latched fault keeps shutdown_o high after every flag has returned low, for as long as rem_delayed_o stays low.
- R9: rem_delayed_o high with no protection flag active clears the fault latch. After remote_off_i returns low, shutdown_o falls on the normal run delay.
- R10: When a protection flag and rem_delayed_o are high together, the latch stays set, so the supply remains off after the remote request falls.
- R11: While reset is high and on the first cycle after it, shutdown_o and rem_delayed_o are low.
- R12: The under-voltage blanking window restarts when rem_delayed_o falls and counts UV_BLANK_CYC edges from the first edge at which it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| remote_off_i | input | 1 | Synchronous host remote request, high asks for the supply off |
| ov_flag_i | input | N_OV | Over-voltage comparator flags, one per rail, active high |
| uv_flag_i | input | N_UV | Under-voltage comparator flags, one per rail, active high |
| ext_prot_i | input | 1 | Extra protection input, active high |
| shutdown_o | output | 1 | Registered converter inhibit, high means off |
| rem_delayed_o | output | 1 | Filtered remote request for the power-good logic |

## Verification
A remote edge reaches rem_delayed_o on the OFF_DLY_CYC-th or RUN_DLY_CYC-th rising edge, and reaches shutdown_o one edge after that. A protection flag reaches the latch on the first edge that samples it, and reaches shutdown_o on the second. Under-voltage is honoured from the first edge after the blanking counter reaches its limit. The bench drives inputs on falling edges and counts falling edges before each sample. It places checks on the last cycle before each transition and on the first cycle after it, so an off-by-one in any delay or in the blanking window shows up as a wrong level.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Width able to hold the values 0..n inclusive, never below one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Level the filtered remote request may hold.
  typedef enum logic {
    REM_RUN = 1'b0,
    REM_OFF = 1'b1
  } rem_level_e;

endpackage

// File: rtl/psd_asym_filter.sv
module psd_asym_filter
  import psd_pkg::*;
#(
  parameter int unsigned RISE_CYC = 8,
  parameter int unsigned FALL_CYC = 24
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  output logic level_o
);

  localparam int unsigned MAXC = max2(RISE_CYC, FALL_CYC);
  localparam int unsigned CW   = cnt_width(MAXC);

  rem_level_e       level_q;
  logic [CW-1:0]    cnt_q;
  logic [CW-1:0]    lim;
  logic             differs;

  assign differs = (req_i != logic'(level_q));
  assign lim     = req_i ? CW'(RISE_CYC - 1) : CW'(FALL_CYC - 1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      level_q <= REM_RUN;
      cnt_q   <= '0;
    end else if (differs) begin
      if (cnt_q == lim) begin
        level_q <= rem_level_e'(req_i);
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign level_o = logic'(level_q);

  AST_FLIP_TOWARD_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
    (level_o != $past(level_o)) |-> (level_o == $past(req_i))); // R1

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q < CW'(MAXC)); // R3

  AST_NO_CHANGE_WHEN_EQUAL: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i == level_o) |=> $stable(level_o)); // R3

endmodule

// File: rtl/psd_uv_blank.sv
module psd_uv_blank
  import psd_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic hold_i,
  output logic armed_o
);

  localparam int unsigned CW = cnt_width(BLANK_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || hold_i) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(BLANK_CYC)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign armed_o = (cnt_q == CW'(BLANK_CYC));

  AST_HOLD_DISARMS: assert property (@(posedge clk_i) disable iff (rst_i)
    hold_i |=> !armed_o); // R12

  AST_ARMED_STAYS: assert property (@(posedge clk_i) disable iff (rst_i)
    (armed_o && !hold_i) |=> armed_o); // R6

endmodule

// File: rtl/psd_fault_latch.sv
module psd_fault_latch #(
  parameter int unsigned N_OV = 3,
  parameter int unsigned N_UV = 3
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [N_OV-1:0] ov_i,
  input  logic [N_UV-1:0] uv_i,
  input  logic            ext_i,
  input  logic            uv_armed_i,
  input  logic            clear_i,
  output logic            fault_o
);

  logic trip;
  logic fault_q;

  assign trip = (|ov_i) | ext_i | ((|uv_i) & uv_armed_i);

  // Set dominates clear so that a persisting fault keeps the supply off.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fault_q <= 1'b0;
    end else if (trip) begin
      fault_q <= 1'b1;
    end else if (clear_i) begin
      fault_q <= 1'b0;
    end
  end

  assign fault_o = fault_q;

  AST_OV_TRIPS: assert property (@(posedge clk_i) disable iff (rst_i)
    (|ov_i) |=> fault_o); // R4

  AST_EXT_TRIPS: assert property (@(posedge clk_i) disable iff (rst_i)
    ext_i |=> fault_o); // R5

  AST_UV_BLANKED: assert property (@(posedge clk_i) disable iff (rst_i)
    (!uv_armed_i && !(|ov_i) && !ext_i && !fault_o) |=> !fault_o); // R7

  AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (fault_o && !clear_i) |=> fault_o); // R8

  AST_CLEAR_BY_REMOTE: assert property (@(posedge clk_i) disable iff (rst_i)
    (clear_i && !(|ov_i) && !ext_i && !((|uv_i) && uv_armed_i)) |=> !fault_o); // R9

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    (clear_i && ((|ov_i) || ext_i)) |=> fault_o); // R10

endmodule

// File: rtl/psu_shutdown_ctrl.sv
module psu_shutdown_ctrl #(
  parameter int unsigned OFF_DLY_CYC = 800,
  parameter int unsigned RUN_DLY_CYC = 2400,
  parameter int unsigned UV_BLANK_CYC = 25000,
  parameter int unsigned N_OV = 3,
  parameter int unsigned N_UV = 3
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            remote_off_i,
  input  logic [N_OV-1:0] ov_flag_i,
  input  logic [N_UV-1:0] uv_flag_i,
  input  logic            ext_prot_i,
  output logic            shutdown_o,
  output logic            rem_delayed_o
);

  logic rem_dly;
  logic uv_armed;
  logic fault;
  logic shutdown_q;

  psd_asym_filter #(
    .RISE_CYC (OFF_DLY_CYC),
    .FALL_CYC (RUN_DLY_CYC)
  ) u_filter (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .req_i   (remote_off_i),
    .level_o (rem_dly)
  );

  psd_uv_blank #(
    .BLANK_CYC (UV_BLANK_CYC)
  ) u_blank (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .hold_i  (rem_dly),
    .armed_o (uv_armed)
  );

  psd_fault_latch #(
    .N_OV (N_OV),
    .N_UV (N_UV)
  ) u_latch (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .ov_i       (ov_flag_i),
    .uv_i       (uv_flag_i),
    .ext_i      (ext_prot_i),
    .uv_armed_i (uv_armed),
    .clear_i    (rem_dly),
    .fault_o    (fault)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      shutdown_q <= 1'b0;
    end else begin
      shutdown_q <= rem_dly | fault;
    end
  end

  assign shutdown_o    = shutdown_q;
  assign rem_delayed_o = rem_dly;

  AST_REMOTE_FORCES_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
    rem_delayed_o |=> shutdown_o); // R1

  AST_FAULT_FORCES_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
    fault |=> shutdown_o); // R4

  AST_RUN_WHEN_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rem_delayed_o && !fault) |=> !shutdown_o); // R2

endmodule

// File: tb/psu_shutdown_ctrl_bench.sv
module psu_shutdown_ctrl_bench;

  localparam int unsigned OFF_D = 6;
  localparam int unsigned RUN_D = 14;
  localparam int unsigned BLANK = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rem = 1'b0;
  logic [2:0] ov  = '0;
  logic [2:0] uv  = '0;
  logic       pt  = 1'b0;
  logic       sd;
  logic       rd;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  psu_shutdown_ctrl #(
    .OFF_DLY_CYC  (OFF_D),
    .RUN_DLY_CYC  (RUN_D),
    .UV_BLANK_CYC (BLANK),
    .N_OV         (3),
    .N_UV         (3)
  ) u_psu_shutdown_ctrl (
    .clk_i         (clk),
    .rst_i         (rst),
    .remote_off_i  (rem),
    .ov_flag_i     (ov),
    .uv_flag_i     (uv),
    .ext_prot_i    (pt),
    .shutdown_o    (sd),
    .rem_delayed_o (rd)
  );

  typedef struct packed {
    logic       rem;
    logic [2:0] ov;
    logic       pt;
    logic [7:0] wt;
    logic       sd;
    logic       rd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 3'b000, 1'b0, 8'd5,  1'b0, 1'b0, 4'd1},  // R1 one edge before filter flips
    '{1'b1, 3'b000, 1'b0, 8'd1,  1'b0, 1'b1, 4'd1},  // R1 filter flipped
    '{1'b1, 3'b000, 1'b0, 8'd1,  1'b1, 1'b1, 4'd1},  // R1 shutdown follows
    '{1'b0, 3'b000, 1'b0, 8'd13, 1'b1, 1'b1, 4'd2},  // R2 before run delay ends
    '{1'b0, 3'b000, 1'b0, 8'd1,  1'b1, 1'b0, 4'd2},  // R2 filter fell
    '{1'b0, 3'b000, 1'b0, 8'd1,  1'b0, 1'b0, 4'd2},  // R2 shutdown released
    '{1'b1, 3'b000, 1'b0, 8'd4,  1'b0, 1'b0, 4'd3},  // R3 short pulse
    '{1'b0, 3'b000, 1'b0, 8'd10, 1'b0, 1'b0, 4'd3},  // R3 reversed
    '{1'b1, 3'b000, 1'b0, 8'd5,  1'b0, 1'b0, 4'd3},  // R3 count restarted
    '{1'b0, 3'b000, 1'b0, 8'd3,  1'b0, 1'b0, 4'd3},  // R3
    '{1'b0, 3'b010, 1'b0, 8'd2,  1'b1, 1'b0, 4'd4},  // R4 ov trip
    '{1'b0, 3'b000, 1'b0, 8'd30, 1'b1, 1'b0, 4'd8},  // R8 latch holds
    '{1'b1, 3'b000, 1'b0, 8'd7,  1'b1, 1'b1, 4'd9},  // R9 remote high clears
    '{1'b0, 3'b000, 1'b0, 8'd14, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b0, 3'b000, 1'b0, 8'd1,  1'b0, 1'b0, 4'd9},  // R9 running again
    '{1'b0, 3'b000, 1'b1, 8'd2,  1'b1, 1'b0, 4'd5},  // R5 extra input trip
    '{1'b1, 3'b000, 1'b1, 8'd8,  1'b1, 1'b1, 4'd10}, // R10 set with clear
    '{1'b0, 3'b000, 1'b1, 8'd16, 1'b1, 1'b0, 4'd10}, // R10 still off
    '{1'b0, 3'b000, 1'b0, 8'd5,  1'b1, 1'b0, 4'd10}, // R10 still latched
    '{1'b1, 3'b000, 1'b0, 8'd8,  1'b1, 1'b1, 4'd10}, // R10 clearing cycle
    '{1'b0, 3'b000, 1'b0, 8'd16, 1'b0, 1'b0, 4'd10}  // R10 recovered
  };

  task automatic check(input logic exp_sd, input logic exp_rd, input string tag);
    total++;
    if (sd !== exp_sd || rd !== exp_rd) begin
      bad++;
      $display("FAIL %s: shutdown=%b rem_delayed=%b expected shutdown=%b rem_delayed=%b",
               tag, sd, rd, exp_sd, exp_rd);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    wait_n(3);
    check(1'b0, 1'b0, "R11 in reset");
    rst = 1'b0;
    wait_n(1);
    check(1'b0, 1'b0, "R11 after reset");
    rem = 1'b0;

    for (int i = 0; i < NV; i++) begin
      rem = TBL[i].rem;
      ov  = TBL[i].ov;
      pt  = TBL[i].pt;
      wait_n(int'(TBL[i].wt));
      check(TBL[i].sd, TBL[i].rd, $sformatf("R%0d row %0d", TBL[i].req, i));
    end

    // Second reset: under-voltage blanking after start-up.
    rst = 1'b1; rem = 1'b0; ov = '0; pt = 1'b0; uv = '0;
    wait_n(3);
    check(1'b0, 1'b0, "R11 second reset");
    rst = 1'b0;
    uv  = 3'b001;
    wait_n(BLANK - 1);
    check(1'b0, 1'b0, "R7 uv inside window");
    uv = '0;
    wait_n(5);
    check(1'b0, 1'b0, "R7 no trip after window");
    uv = 3'b100;
    wait_n(2);
    check(1'b1, 1'b0, "R6 uv trip once armed");

    // Clear and confirm the window restarts on the filtered remote fall.
    uv  = '0;
    rem = 1'b1;
    wait_n(OFF_D + 2);
    check(1'b1, 1'b1, "R9 clear phase");
    rem = 1'b0;
    wait_n(RUN_D + 1);
    check(1'b0, 1'b0, "R9 running after clear");
    uv = 3'b001;
    wait_n(20);
    check(1'b0, 1'b0, "R12 uv blanked after restart");
    uv = '0;
    wait_n(BLANK);
    check(1'b0, 1'b0, "R12 idle after window");
    uv = 3'b010;
    wait_n(2);
    check(1'b1, 1'b0, "R12 uv trips after restarted window");

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

endmodule